// File: doc/BRIEF.md
# Margin-Selectable Voltage-Code Ramp Controller

This block keeps the output-voltage target of a single regulator channel and walks a voltage identification (VID) code toward it at a programmed slew rate. Through a simple register write port it takes three target codes (nominal, low margin, high margin), an operation byte, a configuration word and a transition-rate word. When the configuration allows it, a four-bit margin field inside the operation byte picks which target is active. The same field also decides whether over- and undervoltage faults are masked while margining.

The ramp moves the code one LSB at a time. The spacing between steps is a cycle count taken from the rate word. The rate word is a linear-format number whose exponent field is fixed and whose mantissa gives the rate in sixteenths of a mV/µs. The caller chooses a fast, slow or soft-start profile, and the slow and soft-start profiles divide the programmed rate. Rate words outside the supported set, and margin fields with both upper bits set, are rejected and flagged for one cycle. When the target changes mid-ramp, the code turns around from wherever it is, with no jump. A one-cycle pulse marks the step that lands on the target.

Top module: `vid_margin_ramp`

## Requirements
- R1: After reset the VID code, every target code, the operation byte, the configuration and the rate are zero, and `fault_mask`, `rate_err`, `cmd_err` and `ramp_done` are 0. With no valid rate word written since reset, the code never moves.
- R2: A write with `wr_en`=1 stores `wr_data` by address: 0 nominal target, 1 low-margin target, 2 high-margin target, 3 operation byte (`wr_data[7:0]`), 4 configuration, 5 rate word. The configuration bits are bit0 obey-operation, bit1 slow-half and bit2 soft-start-sixteenth. Writes to addresses 6 and 7 change nothing.
- R3: While obey-operation is 0, the active target is the nominal code and `fault_mask` is 0, whatever the operation byte holds.
- R4: While obey-operation is 1, the margin field (operation bits 5:2) selects the target: 00xx gives nominal, 01xx gives low margin and 10xx gives high margin. So 80h gives nominal, 94h gives low and A4h gives high.
- R5: `fault_mask` is 1 only when obey-operation is 1, the field selects low or high margin, and its two low bits are 01. A field ending in 10 (for example A8h or 98h) leaves it 0.
- R6: An operation write whose field is 11xx is discarded: the stored byte and the target stay as they were, and `cmd_err` pulses for the one cycle after the write edge.
- R7: A valid rate word has bits 15:11 = 11100b and a mantissa m (bits 10:0) that is either 80·k or 5·k, for k from 1 to 8. The step spacing is ceil(LSB_UV·16·div·CLK_MHZ / (1000·m)) cycles.
- R8: A rate write that is not valid pulses `rate_err` for one cycle and keeps the previous rate.
- R9: `ramp_mode` 0 or 3 uses div=1. Mode 1 (slow) uses div=2 if slow-half is set and 4 otherwise. Mode 2 (soft-start) uses div=16 if soft-start-sixteenth is set and 4 otherwise.
- R10: The code changes by exactly one LSB toward the target per step. The first step after a target change lands on the P-th clock edge after the write edge, where P is the step spacing. At the target, the code holds.
- R11: A target change during a ramp continues or reverses from the present code, with every change still one LSB.
- R12: `ramp_done` is high for one cycle, on the cycle after the step that makes the code equal to the target that was active at that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| ramp_mode | input | 2 | 0 fast, 1 slow, 2 soft-start, 3 fast |
| vid_code | output | VID_W | Present ramped VID code |
| target_code | output | VID_W | Active target code |
| fault_mask | output | 1 | 1 masks over/undervoltage faults |
| ramp_done | output | 1 | One-cycle pulse when a step reaches the target |
| rate_err | output | 1 | One-cycle pulse on an unsupported rate word |
| cmd_err | output | 1 | One-cycle pulse on a rejected margin field |

## Verification
A step that lands on the target and a write that moves the target can happen on the same clock edge. The bench provokes this by timing a nominal-target write onto the exact edge of the landing step. It then checks three things: `ramp_done` still pulses for the old target, `target_code` already shows the new value, and the code goes on toward the new value one LSB at a time. A reversal mid-ramp is also watched every cycle to confirm that no change is larger than one LSB.

// File: rtl/vmr_pkg.sv
// Package: shared constants, types and the step-spacing arithmetic for the
// VID margin ramp. Assumes the rate mantissa is in 1/16 mV/us units.
package vmr_pkg;

    typedef enum logic [1:0] {
        RAMP_FAST = 2'd0,
        RAMP_SLOW = 2'd1,
        RAMP_SOFT = 2'd2,
        RAMP_ALT  = 2'd3
    } ramp_mode_e;

    localparam logic [2:0] ADDR_NOM  = 3'd0;
    localparam logic [2:0] ADDR_LOW  = 3'd1;
    localparam logic [2:0] ADDR_HIGH = 3'd2;
    localparam logic [2:0] ADDR_OPER = 3'd3;
    localparam logic [2:0] ADDR_CFG  = 3'd4;
    localparam logic [2:0] ADDR_RATE = 3'd5;

    localparam logic [4:0] RATE_EXP_FIELD = 5'b11100;
    localparam int unsigned RATE_SLOTS = 8;

    // Selected rate: family (0 = fast x80, 1 = low x5) and multiplier index
    typedef struct packed {
        logic       valid;
        logic       low_fam;
        logic [2:0] k;
    } rate_sel_t;

    // Clock cycles per LSB step, rounded up so the ramp is never too fast
    function automatic longint unsigned step_cycles(
        input longint unsigned lsb_uv,
        input longint unsigned clk_mhz,
        input longint unsigned mant,
        input longint unsigned div
    );
        longint unsigned num;
        longint unsigned den;
        num = lsb_uv * 16 * div * clk_mhz;
        den = 1000 * mant;
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/vmr_regs.sv
// Module: register store and margin decode. Holds the three target codes,
// the operation byte and the configuration bits, picks the active target and
// drives the fault-mask flag. Assumes one write per cycle at most.
module vmr_regs
    import vmr_pkg::*;
#(
    parameter int unsigned VID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [15:0]      wr_data,
    output logic [VID_W-1:0] target_code,
    output logic             fault_mask,
    output logic             cmd_err,
    output logic             slow_half,
    output logic             ss_sixteenth,
    output logic             rate_wr,
    output logic [15:0]      rate_word
);

    logic [VID_W-1:0] nom_q, low_q, high_q;
    logic [7:0]       oper_q;
    logic [2:0]       cfg_q;
    logic [3:0]       field;
    logic             obey;
    logic             oper_bad;

    assign obey         = cfg_q[0];
    assign slow_half    = cfg_q[1];
    assign ss_sixteenth = cfg_q[2];
    assign field        = oper_q[5:2];
    assign oper_bad     = (wr_data[5:4] == 2'b11);
    assign rate_wr      = wr_en && (wr_addr == ADDR_RATE);
    assign rate_word    = wr_data;

    // Purpose: capture the three target codes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nom_q  <= '0;
            low_q  <= '0;
            high_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_NOM)  nom_q  <= wr_data[VID_W-1:0];
            if (wr_addr == ADDR_LOW)  low_q  <= wr_data[VID_W-1:0];
            if (wr_addr == ADDR_HIGH) high_q <= wr_data[VID_W-1:0];
        end
    end

    // Purpose: capture operation byte, rejecting the reserved margin field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oper_q  <= '0;
            cmd_err <= 1'b0;
        end else begin
            cmd_err <= 1'b0;
            if (wr_en && wr_addr == ADDR_OPER) begin
                if (oper_bad) cmd_err <= 1'b1;
                else          oper_q  <= wr_data[7:0];
            end
        end
    end

    // Purpose: capture configuration bits
    always_ff @(posedge clk) begin
        if (!rst_n)                             cfg_q <= '0;
        else if (wr_en && wr_addr == ADDR_CFG)  cfg_q <= wr_data[2:0];
    end

    // Purpose: choose the active target and the fault-mask flag
    always_comb begin
        target_code = nom_q;
        fault_mask  = 1'b0;
        if (obey) begin
            unique case (field[3:2])
                2'b01: begin
                    target_code = low_q;
                    fault_mask  = (field[1:0] == 2'b01);
                end
                2'b10: begin
                    target_code = high_q;
                    fault_mask  = (field[1:0] == 2'b01);
                end
                default: target_code = nom_q;
            endcase
        end
    end

    AST_REJECT_KEEPS_OPER: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $stable(oper_q)); // R6
    AST_OPER_FIELD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        oper_q[5:4] != 2'b11); // R6
    AST_MASK_OFF_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_mask && nom_q != low_q && nom_q != high_q) |-> target_code != nom_q); // R5

endmodule

// File: rtl/vmr_rate.sv
// Module: rate word decoder and step-spacing lookup. Validates the word,
// keeps the last good selection and turns it and the ramp profile into a
// cycle count. Assumes the spacing table is fixed at elaboration.
module vmr_rate
    import vmr_pkg::*;
#(
    parameter int unsigned CLK_MHZ = 200,
    parameter int unsigned LSB_UV  = 5000,
    parameter int unsigned CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rate_wr,
    input  logic [15:0]      rate_word,
    input  logic [1:0]       ramp_mode,
    input  logic             slow_half,
    input  logic             ss_sixteenth,
    output logic             rate_ok,
    output logic [CNT_W-1:0] period,
    output logic             rate_err
);

    localparam int unsigned N_DIV = 4;
    localparam int unsigned N_IDX = 2 * RATE_SLOTS;

    rate_sel_t        sel_q;
    rate_sel_t        sel_d;
    logic [1:0]       div_idx;
    logic [CNT_W-1:0] tbl [N_DIV][N_IDX];

    // Build the spacing table: one entry per divider and per rate slot
    for (genvar d = 0; d < N_DIV; d++) begin : g_div
        localparam longint unsigned DIV = (d == 0) ? 1 : (d == 1) ? 2 : (d == 2) ? 4 : 16;
        for (genvar g = 0; g < N_IDX; g++) begin : g_slot
            localparam longint unsigned MANT =
                (g >= RATE_SLOTS) ? 5 * (g - RATE_SLOTS + 1) : 80 * (g + 1);
            localparam logic [CNT_W-1:0] SPACING =
                CNT_W'(step_cycles(LSB_UV, CLK_MHZ, MANT, DIV));
            assign tbl[d][g] = SPACING;
        end
    end

    // Purpose: match the written word against the supported set
    always_comb begin
        sel_d = '0;
        if (rate_word[15:11] == RATE_EXP_FIELD) begin
            for (int i = 0; i < RATE_SLOTS; i++) begin
                if (rate_word[10:0] == 11'(80 * (i + 1))) begin
                    sel_d.valid   = 1'b1;
                    sel_d.low_fam = 1'b0;
                    sel_d.k       = 3'(i);
                end
                if (rate_word[10:0] == 11'(5 * (i + 1))) begin
                    sel_d.valid   = 1'b1;
                    sel_d.low_fam = 1'b1;
                    sel_d.k       = 3'(i);
                end
            end
        end
    end

    // Purpose: hold the last valid selection and flag rejected words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= '0;
            rate_err <= 1'b0;
        end else begin
            rate_err <= rate_wr && !sel_d.valid;
            if (rate_wr && sel_d.valid) sel_q <= sel_d;
        end
    end

    // Purpose: pick the divider for the requested ramp profile
    always_comb begin
        unique case (ramp_mode_e'(ramp_mode))
            RAMP_SLOW: div_idx = slow_half ? 2'd1 : 2'd2;
            RAMP_SOFT: div_idx = ss_sixteenth ? 2'd3 : 2'd2;
            default:   div_idx = 2'd0;
        endcase
    end

    assign rate_ok = sel_q.valid;
    assign period  = tbl[div_idx][{sel_q.low_fam, sel_q.k}];

    AST_BAD_WORD_KEEPS_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        rate_err |-> $stable(sel_q)); // R8
    AST_PERIOD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rate_ok |-> period != '0); // R7

endmodule

// File: rtl/vmr_stepper.sv
// Module: the VID ramp. Moves the code one LSB toward the target each time
// the spacing counter expires and pulses done on the landing step. Assumes
// period is at least 1 whenever rate_ok is set.
module vmr_stepper #(
    parameter int unsigned VID_W = 8,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VID_W-1:0] target,
    input  logic             rate_ok,
    input  logic [CNT_W-1:0] period,
    output logic [VID_W-1:0] code,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;
    logic [VID_W-1:0] next_code;
    logic             expire;

    assign next_code = (target > code) ? code + 1'b1 : code - 1'b1;
    assign expire    = (period <= CNT_W'(1)) || (cnt_q >= period - 1'b1);

    // Purpose: count spacing cycles and step the code toward the target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code  <= '0;
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!rate_ok || code == target) begin
                cnt_q <= '0;
            end else if (expire) begin
                cnt_q <= '0;
                code  <= next_code;
                done  <= (next_code == target);
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_ONE_LSB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (code == $past(code)) || (code == $past(code) + 1'b1) || (code == $past(code) - 1'b1)); // R10
    AST_HOLD_AT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code) == $past(target)) |-> (code == $past(code))); // R10
    AST_DONE_ON_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (code == $past(target))); // R12
    AST_IDLE_WITHOUT_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rate_ok) |-> $stable(code)); // R1

endmodule

// File: rtl/vid_margin_ramp.sv
// Module: top of the margin-selectable VID ramp for one channel. Wires the
// register store, the rate decoder and the stepper together. Assumes a single
// clock and a synchronous active-low reset.
module vid_margin_ramp
    import vmr_pkg::*;
#(
    parameter int unsigned VID_W   = 8,
    parameter int unsigned CLK_MHZ = 200,
    parameter int unsigned LSB_UV  = 5000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [15:0]      wr_data,
    input  logic [1:0]       ramp_mode,
    output logic [VID_W-1:0] vid_code,
    output logic [VID_W-1:0] target_code,
    output logic             fault_mask,
    output logic             ramp_done,
    output logic             rate_err,
    output logic             cmd_err
);

    localparam longint unsigned MAX_SPACING = step_cycles(LSB_UV, CLK_MHZ, 5, 16);
    localparam int unsigned     CNT_W       = $clog2(MAX_SPACING + 1);

    logic             slow_half;
    logic             ss_sixteenth;
    logic             rate_wr;
    logic [15:0]      rate_word;
    logic             rate_ok;
    logic [CNT_W-1:0] period;

    vmr_regs #(.VID_W(VID_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .target_code  (target_code),
        .fault_mask   (fault_mask),
        .cmd_err      (cmd_err),
        .slow_half    (slow_half),
        .ss_sixteenth (ss_sixteenth),
        .rate_wr      (rate_wr),
        .rate_word    (rate_word)
    );

    vmr_rate #(.CLK_MHZ(CLK_MHZ), .LSB_UV(LSB_UV), .CNT_W(CNT_W)) u_rate (
        .clk          (clk),
        .rst_n        (rst_n),
        .rate_wr      (rate_wr),
        .rate_word    (rate_word),
        .ramp_mode    (ramp_mode),
        .slow_half    (slow_half),
        .ss_sixteenth (ss_sixteenth),
        .rate_ok      (rate_ok),
        .period       (period),
        .rate_err     (rate_err)
    );

    vmr_stepper #(.VID_W(VID_W), .CNT_W(CNT_W)) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .target  (target_code),
        .rate_ok (rate_ok),
        .period  (period),
        .code    (vid_code),
        .done    (ramp_done)
    );

endmodule

// File: tb/vid_margin_ramp_test.sv
// Directed bench: one task per scenario, each checking its own results.
module vid_margin_ramp_test;

    localparam int unsigned VID_W   = 8;
    localparam int unsigned CLK_MHZ = 200;
    localparam int unsigned LSB_UV  = 5000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [15:0]      wr_data = '0;
    logic [1:0]       ramp_mode = '0;
    logic [VID_W-1:0] vid_code, target_code;
    logic             fault_mask, ramp_done, rate_err, cmd_err;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    vid_margin_ramp #(.VID_W(VID_W), .CLK_MHZ(CLK_MHZ), .LSB_UV(LSB_UV)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ramp_mode(ramp_mode), .vid_code(vid_code), .target_code(target_code),
        .fault_mask(fault_mask), .ramp_done(ramp_done), .rate_err(rate_err), .cmd_err(cmd_err)
    );

    function automatic int exp_spacing(input int mant, input int div);
        longint num, den;
        num = longint'(LSB_UV) * 16 * div * CLK_MHZ;
        den = 1000 * mant;
        return int'((num + den - 1) / den);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One write; returns at the falling edge after the write edge
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle(output int dones);
        int n;
        dones = 0; n = 0;
        while (vid_code != target_code && n < 100000) begin
            @(negedge clk);
            if (ramp_done) dones++;
            n++;
        end
    endtask

    // Raise nominal target by two and measure edges until the first step
    task automatic measure(input int exp_p, input string req);
        int n, dn;
        logic [VID_W-1:0] c0;
        c0 = vid_code;
        wr(3'd0, 16'(c0 + 2));
        n = 0;
        while (vid_code == c0 && n < 100000) begin
            @(negedge clk);
            n++;
        end
        check(n == exp_p, req, n, exp_p);
        settle(dn);
        check(vid_code == c0 + 2, req, int'(vid_code), int'(c0 + 2));
    endtask

    task automatic t_reset;
        check(vid_code == 0 && target_code == 0, "R1 reset codes", int'(vid_code), 0);
        check(!fault_mask && !ramp_done && !rate_err && !cmd_err, "R1 reset flags",
              int'({fault_mask, ramp_done, rate_err, cmd_err}), 0);
        wr(3'd0, 16'd3);
        repeat (300) @(negedge clk);
        check(vid_code == 0, "R1 no rate no motion", int'(vid_code), 0);
    endtask

    task automatic t_fast_first;
        int dn;
        wr(3'd5, 16'hE280);
        check(!rate_err, "R7 valid word no error", int'(rate_err), 0);
        // target already 3, ramp starts at the rate write edge
        settle(dn);
        check(vid_code == 3, "R10 reaches target", int'(vid_code), 3);
        check(dn == 1, "R12 single done pulse", dn, 1);
        @(negedge clk);
        check(!ramp_done, "R12 done is one cycle", int'(ramp_done), 0);
        measure(exp_spacing(640, 1), "R10 fast first step");
    endtask

    task automatic t_profiles;
        ramp_mode = 2'd1;
        wr(3'd4, 16'h0000);
        measure(exp_spacing(640, 4), "R9 slow quarter");
        wr(3'd4, 16'h0002);
        measure(exp_spacing(640, 2), "R9 slow half");
        ramp_mode = 2'd2;
        wr(3'd4, 16'h0000);
        measure(exp_spacing(640, 4), "R9 softstart quarter");
        wr(3'd4, 16'h0004);
        measure(exp_spacing(640, 16), "R9 softstart sixteenth");
        ramp_mode = 2'd3;
        measure(exp_spacing(640, 1), "R9 mode3 fast");
        ramp_mode = 2'd0;
        wr(3'd4, 16'h0000);
    endtask

    task automatic t_rate_words;
        wr(3'd5, 16'hE0F0);
        measure(exp_spacing(240, 1), "R7 rounded up 15mV");
        wr(3'd5, 16'hE005);
        measure(exp_spacing(5, 1), "R7 low family");
        wr(3'd5, 16'hE280);
        wr(3'd5, 16'hE281);
        check(rate_err, "R8 bad mantissa flagged", int'(rate_err), 1);
        wr(3'd5, 16'h0050);
        check(rate_err, "R8 bad exponent flagged", int'(rate_err), 1);
        @(negedge clk);
        check(!rate_err, "R8 flag one cycle", int'(rate_err), 0);
        measure(exp_spacing(640, 1), "R8 rate kept");
    endtask

    task automatic t_margin;
        int dn;
        logic [VID_W-1:0] nom;
        nom = vid_code;
        wr(3'd1, 16'(nom + 4));
        wr(3'd2, 16'(nom + 8));
        wr(3'd3, 16'h00A4);
        check(target_code == nom && !fault_mask, "R3 ignored without obey",
              int'(target_code), int'(nom));
        wr(3'd4, 16'h0001);
        check(target_code == nom + 8, "R4 A4h high", int'(target_code), int'(nom + 8));
        check(fault_mask, "R5 A4h masks", int'(fault_mask), 1);
        wr(3'd3, 16'h0094);
        check(target_code == nom + 4 && fault_mask, "R4 94h low masked", int'(target_code), int'(nom + 4));
        wr(3'd3, 16'h00A8);
        check(target_code == nom + 8 && !fault_mask, "R5 A8h acts on faults",
              int'(fault_mask), 0);
        wr(3'd3, 16'h0098);
        check(target_code == nom + 4 && !fault_mask, "R5 98h acts on faults",
              int'(fault_mask), 0);
        wr(3'd3, 16'h00B0);
        check(cmd_err, "R6 11xx flagged", int'(cmd_err), 1);
        check(target_code == nom + 4 && !fault_mask, "R6 target kept", int'(target_code), int'(nom + 4));
        @(negedge clk);
        check(!cmd_err, "R6 flag one cycle", int'(cmd_err), 0);
        wr(3'd6, 16'h00FF);
        wr(3'd7, 16'h0000);
        check(target_code == nom + 4 && !fault_mask && !rate_err && !cmd_err,
              "R2 unused addresses ignored", int'(target_code), int'(nom + 4));
        wr(3'd3, 16'h0080);
        check(target_code == nom && !fault_mask, "R4 80h nominal", int'(target_code), int'(nom));
        settle(dn);
        wr(3'd4, 16'h0000);
        check(vid_code == nom, "R2 code stays nominal", int'(vid_code), int'(nom));
    endtask

    task automatic t_reverse;
        int n, jumps, hi;
        logic [VID_W-1:0] c0, prev;
        c0 = vid_code;
        wr(3'd0, 16'(c0 + 20));
        n = 0;
        while (vid_code != c0 + 5 && n < 10000) begin @(negedge clk); n++; end
        wr(3'd0, 16'(c0));
        jumps = 0; hi = int'(vid_code); prev = vid_code; n = 0;
        while (vid_code != c0 && n < 10000) begin
            @(negedge clk);
            if (vid_code != prev && vid_code != prev + 1 && vid_code != prev - 1) jumps++;
            if (int'(vid_code) > hi) hi = int'(vid_code);
            prev = vid_code; n++;
        end
        check(jumps == 0, "R11 no jump on reverse", jumps, 0);
        check(hi <= int'(c0) + 6, "R11 turns around promptly", hi, int'(c0) + 6);
        check(vid_code == c0, "R11 ends at new target", int'(vid_code), int'(c0));
    endtask

    task automatic t_collision;
        int p, dn;
        logic [VID_W-1:0] c0;
        p = exp_spacing(640, 1);
        c0 = vid_code;
        wr(3'd0, 16'(c0 + 1));
        repeat (p - 1) @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'(c0 + 3);
        @(negedge clk);
        wr_en = 1'b0;
        check(ramp_done, "R12 done on landing step despite retarget", int'(ramp_done), 1);
        check(vid_code == c0 + 1, "R12 landed code", int'(vid_code), int'(c0 + 1));
        check(target_code == c0 + 3, "R11 new target active", int'(target_code), int'(c0 + 3));
        settle(dn);
        check(vid_code == c0 + 3 && dn == 1, "R11 continues to new target", int'(vid_code), int'(c0 + 3));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fast_first();
        t_profiles();
        t_rate_words();
        t_margin();
        t_reverse();
        t_collision();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule